// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle 32-bit load/store processor. It steps each instruction through a short series of clock cycles. On every cycle it tells the datapath what to do: read or write memory, load the instruction register, write the register file, pick the ALU inputs and operation, and update the program counter. Its only data input is the 6-bit opcode field of the instruction register.

Each instruction starts with a fetch cycle and a decode cycle. In decode the branch target is also precomputed. After that the path depends on the instruction class: loads take five cycles, stores and register-to-register operations take four, and branches and jumps take three. An opcode outside the supported set takes one cycle that raises an undefined-instruction flag, and then fetch starts again.

The machine is Moore-style. Every control output is a function of the state alone. The outputs are registered, so they change only at a clock edge.

Top module: `mcyc_ctrl`

## Requirements
- R1: Synchronous reset `rst` forces the fetch state. While reset is held, and in the first cycle after it is released, the outputs show the fetch word: `mem_rd_o`=1, `addr_data_o`=0, `ir_wr_o`=1, `alu_a_sel_o`=0, `alu_b_sel_o`=01, `alu_op_o`=00, `pc_wr_o`=1, `pc_src_o`=00, and every other output is 0.
- R2: The cycle after fetch is decode. In decode, `alu_a_sel_o`=0 (PC), `alu_b_sel_o`=11 (sign-extended immediate shifted left 2) and `alu_op_o`=00 (add). Every other output is 0.
- R3: The opcode encodings are: R-type 000000, load 100011, store 101011, branch-equal 000100 and jump 000010. Counted from one fetch to the next, a load takes 5 cycles, a store 4, an R-type 4, a branch 3, a jump 3 and an undefined opcode 3.
- R4: In a load, the third cycle has `alu_a_sel_o`=1, `alu_b_sel_o`=10 and `alu_op_o`=00. The fourth cycle has `mem_rd_o`=1 and `addr_data_o`=1. The fifth cycle has `rf_wr_o`=1, `rf_dst_rd_o`=0 and `rf_from_mem_o`=1. Every other output is 0 in these cycles.
- R5: In a store, the third cycle has the same address word as a load. The fourth cycle has `mem_wr_o`=1 and `addr_data_o`=1, and every other output is 0.
- R6: In an R-type, the third cycle has `alu_a_sel_o`=1, `alu_b_sel_o`=00 and `alu_op_o`=10 (the function field picks the operation). The fourth cycle has `rf_wr_o`=1, `rf_dst_rd_o`=1 and `rf_from_mem_o`=0.
- R7: In a branch, the third cycle has `alu_a_sel_o`=1, `alu_b_sel_o`=00, `alu_op_o`=01 (subtract), `pc_wr_cond_o`=1, `pc_src_o`=01 (ALUOut) and `pc_wr_o`=0.
- R8: In a jump, the third cycle has `pc_wr_o`=1 and `pc_src_o`=10 (jump target), and every other output is 0.
- R9: For an undefined opcode, the third cycle has `undef_op_o`=1 and every other output 0. `undef_op_o` is 0 in every other cycle.
- R10: The opcode input is used only in decode, and in the address cycle of a load or store. Its value in any other cycle has no effect on the outputs.
- R11: `mem_rd_o` and `mem_wr_o` are never both 1. At most one of `mem_wr_o`, `rf_wr_o`, `pc_wr_cond_o` and `undef_op_o` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode_i | input | 6 | Opcode field of the instruction register |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| addr_data_o | output | 1 | Memory address select: 0 = PC, 1 = ALUOut |
| ir_wr_o | output | 1 | Instruction register write |
| rf_wr_o | output | 1 | Register file write |
| rf_dst_rd_o | output | 1 | Write address select: 0 = rt, 1 = rd |
| rf_from_mem_o | output | 1 | Write data select: 0 = ALUOut, 1 = MDR |
| alu_a_sel_o | output | 1 | ALU A select: 0 = PC, 1 = A |
| alu_b_sel_o | output | 2 | ALU B select: 00 = B, 01 = 4, 10 = immediate, 11 = immediate shifted left 2 |
| alu_op_o | output | 2 | ALU operation: 00 = add, 01 = subtract, 10 = function field |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write when operands are equal |
| pc_src_o | output | 2 | PC source: 00 = ALU result, 01 = ALUOut, 10 = jump target |
| undef_op_o | output | 1 | Undefined opcode seen |

## Verification
The assertions check on every cycle that memory read and write are never both active and that the write-type strobes are mutually exclusive. They also check the cycle-to-cycle links between steps: an instruction-register write is followed by a quiet decode cycle, a data-memory read is followed by the register write-back from MDR, and each final step of an instruction is followed by fetch. The per-class control words, the cycle count of each class, reset taken in the middle of an instruction, and the fact that the opcode is ignored outside the cycles that read it can only be shown by the bench. The bench does this with directed and random instruction streams, and it drives random opcodes in every cycle that should ignore them.

// File: rtl/mcyc_ctrl_pkg.sv
package mcyc_ctrl_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_MEMADR  = 4'd2,
        ST_MEMRD   = 4'd3,
        ST_MEMWB   = 4'd4,
        ST_MEMWR   = 4'd5,
        ST_EXEC    = 4'd6,
        ST_RTWB    = 4'd7,
        ST_BRANCH  = 4'd8,
        ST_JUMP    = 4'd9,
        ST_UNDEF   = 4'd10
    } state_t;

    typedef enum logic [2:0] {
        OC_LOAD,
        OC_STORE,
        OC_RTYPE,
        OC_BRANCH,
        OC_JUMP,
        OC_UNDEF
    } opclass_t;

    localparam logic [1:0] BSEL_REG   = 2'b00;
    localparam logic [1:0] BSEL_FOUR  = 2'b01;
    localparam logic [1:0] BSEL_IMM   = 2'b10;
    localparam logic [1:0] BSEL_IMMSH = 2'b11;

    localparam logic [1:0] AOP_ADD    = 2'b00;
    localparam logic [1:0] AOP_SUB    = 2'b01;
    localparam logic [1:0] AOP_FUNCT  = 2'b10;

    localparam logic [1:0] PSRC_ALU   = 2'b00;
    localparam logic [1:0] PSRC_OUT   = 2'b01;
    localparam logic [1:0] PSRC_JMP   = 2'b10;

    typedef struct packed {
        logic       mem_rd;
        logic       mem_wr;
        logic       addr_data;
        logic       ir_wr;
        logic       rf_wr;
        logic       rf_dst_rd;
        logic       rf_from_mem;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_op;
        logic       pc_wr;
        logic       pc_wr_cond;
        logic [1:0] pc_src;
        logic       undef_op;
    } ctrl_t;

endpackage

// File: rtl/mcyc_op_decode.sv
module mcyc_op_decode
    import mcyc_ctrl_pkg::*;
#(
    parameter int              OP_W      = 6,
    parameter logic [OP_W-1:0] OP_RTYPE  = 6'b000000,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
    parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
    parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
    input  logic [OP_W-1:0] opcode,
    output opclass_t        opclass
);

    always_comb begin
        if (opcode == OP_LOAD)        opclass = OC_LOAD;
        else if (opcode == OP_STORE)  opclass = OC_STORE;
        else if (opcode == OP_RTYPE)  opclass = OC_RTYPE;
        else if (opcode == OP_BRANCH) opclass = OC_BRANCH;
        else if (opcode == OP_JUMP)   opclass = OC_JUMP;
        else                          opclass = OC_UNDEF;
    end

endmodule

// File: rtl/mcyc_next_state.sv
module mcyc_next_state
    import mcyc_ctrl_pkg::*;
(
    input  state_t   cur,
    input  opclass_t opclass,
    output state_t   nxt
);

    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (opclass)
                    OC_LOAD,
                    OC_STORE:  nxt = ST_MEMADR;
                    OC_RTYPE:  nxt = ST_EXEC;
                    OC_BRANCH: nxt = ST_BRANCH;
                    OC_JUMP:   nxt = ST_JUMP;
                    default:   nxt = ST_UNDEF;
                endcase
            end
            ST_MEMADR: nxt = (opclass == OC_STORE) ? ST_MEMWR : ST_MEMRD;
            ST_MEMRD:  nxt = ST_MEMWB;
            ST_EXEC:   nxt = ST_RTWB;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcyc_ctrl_word.sv
module mcyc_ctrl_word
    import mcyc_ctrl_pkg::*;
(
    input  state_t st,
    output ctrl_t  word
);

    always_comb begin
        word = '0;
        unique case (st)
            ST_FETCH: begin
                word.mem_rd    = 1'b1;
                word.ir_wr     = 1'b1;
                word.alu_b_sel = BSEL_FOUR;
                word.alu_op    = AOP_ADD;
                word.pc_wr     = 1'b1;
                word.pc_src    = PSRC_ALU;
            end
            ST_DECODE: begin
                word.alu_b_sel = BSEL_IMMSH;
                word.alu_op    = AOP_ADD;
            end
            ST_MEMADR: begin
                word.alu_a_sel = 1'b1;
                word.alu_b_sel = BSEL_IMM;
                word.alu_op    = AOP_ADD;
            end
            ST_MEMRD: begin
                word.mem_rd    = 1'b1;
                word.addr_data = 1'b1;
            end
            ST_MEMWB: begin
                word.rf_wr       = 1'b1;
                word.rf_from_mem = 1'b1;
            end
            ST_MEMWR: begin
                word.mem_wr    = 1'b1;
                word.addr_data = 1'b1;
            end
            ST_EXEC: begin
                word.alu_a_sel = 1'b1;
                word.alu_b_sel = BSEL_REG;
                word.alu_op    = AOP_FUNCT;
            end
            ST_RTWB: begin
                word.rf_wr     = 1'b1;
                word.rf_dst_rd = 1'b1;
            end
            ST_BRANCH: begin
                word.alu_a_sel  = 1'b1;
                word.alu_b_sel  = BSEL_REG;
                word.alu_op     = AOP_SUB;
                word.pc_wr_cond = 1'b1;
                word.pc_src     = PSRC_OUT;
            end
            ST_JUMP: begin
                word.pc_wr  = 1'b1;
                word.pc_src = PSRC_JMP;
            end
            ST_UNDEF: begin
                word.undef_op = 1'b1;
            end
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcyc_ctrl_pkg::*;
#(
    parameter int              OP_W      = 6,
    parameter logic [OP_W-1:0] OP_RTYPE  = 6'b000000,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
    parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
    parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode_i,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic            addr_data_o,
    output logic            ir_wr_o,
    output logic            rf_wr_o,
    output logic            rf_dst_rd_o,
    output logic            rf_from_mem_o,
    output logic            alu_a_sel_o,
    output logic [1:0]      alu_b_sel_o,
    output logic [1:0]      alu_op_o,
    output logic            pc_wr_o,
    output logic            pc_wr_cond_o,
    output logic [1:0]      pc_src_o,
    output logic            undef_op_o
);

    typedef struct packed {
        state_t st;
        ctrl_t  ctrl;
    } regs_t;

    regs_t    r_d, r_q;
    opclass_t opclass;
    state_t   st_next;
    ctrl_t    word_next;
    ctrl_t    word_reset;

    mcyc_op_decode #(
        .OP_W      (OP_W),
        .OP_RTYPE  (OP_RTYPE),
        .OP_LOAD   (OP_LOAD),
        .OP_STORE  (OP_STORE),
        .OP_BRANCH (OP_BRANCH),
        .OP_JUMP   (OP_JUMP)
    ) u_dec (
        .opcode  (opcode_i),
        .opclass (opclass)
    );

    mcyc_next_state u_ns (
        .cur     (r_q.st),
        .opclass (opclass),
        .nxt     (st_next)
    );

    mcyc_ctrl_word u_word_nxt (
        .st   (st_next),
        .word (word_next)
    );

    mcyc_ctrl_word u_word_rst (
        .st   (ST_FETCH),
        .word (word_reset)
    );

    always_comb begin
        r_d = r_q;
        if (rst) begin
            r_d.st   = ST_FETCH;
            r_d.ctrl = word_reset;
        end else begin
            r_d.st   = st_next;
            r_d.ctrl = word_next;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign mem_rd_o      = r_q.ctrl.mem_rd;
    assign mem_wr_o      = r_q.ctrl.mem_wr;
    assign addr_data_o   = r_q.ctrl.addr_data;
    assign ir_wr_o       = r_q.ctrl.ir_wr;
    assign rf_wr_o       = r_q.ctrl.rf_wr;
    assign rf_dst_rd_o   = r_q.ctrl.rf_dst_rd;
    assign rf_from_mem_o = r_q.ctrl.rf_from_mem;
    assign alu_a_sel_o   = r_q.ctrl.alu_a_sel;
    assign alu_b_sel_o   = r_q.ctrl.alu_b_sel;
    assign alu_op_o      = r_q.ctrl.alu_op;
    assign pc_wr_o       = r_q.ctrl.pc_wr;
    assign pc_wr_cond_o  = r_q.ctrl.pc_wr_cond;
    assign pc_src_o      = r_q.ctrl.pc_src;
    assign undef_op_o    = r_q.ctrl.undef_op;

    // R11: memory strobes exclusive
    a_r11_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_wr_o));

    // R11: at most one write-type strobe
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_wr_o, rf_wr_o, pc_wr_cond_o, undef_op_o}));

    // R2: fetch is followed by a decode cycle with no writes
    a_r2_quiet_decode: assert property (@(posedge clk) disable iff (rst)
        ir_wr_o |=> !ir_wr_o && !pc_wr_o && !mem_rd_o && !mem_wr_o && !rf_wr_o
                    && alu_b_sel_o == BSEL_IMMSH);

    // R4: data read is followed by write-back from memory data
    a_r4_read_then_wb: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && addr_data_o) |=> (rf_wr_o && rf_from_mem_o && !rf_dst_rd_o));

    // R3: final steps of every class return to fetch
    a_r3_store_ends: assert property (@(posedge clk) disable iff (rst)
        mem_wr_o |=> ir_wr_o);
    a_r3_rfwr_ends: assert property (@(posedge clk) disable iff (rst)
        rf_wr_o |=> ir_wr_o);
    a_r7_branch_ends: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond_o |=> ir_wr_o);
    a_r8_jump_ends: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_o && pc_src_o == PSRC_JMP) |=> ir_wr_o);
    a_r9_undef_ends: assert property (@(posedge clk) disable iff (rst)
        undef_op_o |=> ir_wr_o && !undef_op_o);

endmodule

// File: tb/mcyc_ctrl_test.sv
`timescale 1ns/1ps
module mcyc_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       mem_rd, mem_wr, addr_data, ir_wr, rf_wr, rf_dst_rd, rf_from_mem;
    logic       alu_a_sel, pc_wr, pc_wr_cond, undef_op;
    logic [1:0] alu_b_sel, alu_op, pc_src;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mcyc_ctrl uut (
        .clk(clk), .rst(rst), .opcode_i(opcode),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .addr_data_o(addr_data),
        .ir_wr_o(ir_wr), .rf_wr_o(rf_wr), .rf_dst_rd_o(rf_dst_rd),
        .rf_from_mem_o(rf_from_mem), .alu_a_sel_o(alu_a_sel),
        .alu_b_sel_o(alu_b_sel), .alu_op_o(alu_op), .pc_wr_o(pc_wr),
        .pc_wr_cond_o(pc_wr_cond), .pc_src_o(pc_src), .undef_op_o(undef_op)
    );

    localparam int C_LOAD = 0, C_STORE = 1, C_RTYPE = 2, C_BRANCH = 3, C_JUMP = 4, C_UNDEF = 5;

    function automatic logic [16:0] mk(input bit mr, mw, ad, iw, rw, rd, fm, aa,
                                       input logic [1:0] bs, op,
                                       input bit pw, pwc, input logic [1:0] ps, input bit ud);
        return {mr, mw, ad, iw, rw, rd, fm, aa, bs, op, pw, pwc, ps, ud};
    endfunction

    function automatic logic [16:0] expect_word(input int cls, input int k);
        if (k == 1) return mk(1,0,0,1,0,0,0,0,2'b01,2'b00,1,0,2'b00,0);
        if (k == 2) return mk(0,0,0,0,0,0,0,0,2'b11,2'b00,0,0,2'b00,0);
        case (cls)
            C_LOAD, C_STORE: begin
                if (k == 3) return mk(0,0,0,0,0,0,0,1,2'b10,2'b00,0,0,2'b00,0);
                if (cls == C_STORE) return mk(0,1,1,0,0,0,0,0,2'b00,2'b00,0,0,2'b00,0);
                if (k == 4) return mk(1,0,1,0,0,0,0,0,2'b00,2'b00,0,0,2'b00,0);
                return mk(0,0,0,0,1,0,1,0,2'b00,2'b00,0,0,2'b00,0);
            end
            C_RTYPE: begin
                if (k == 3) return mk(0,0,0,0,0,0,0,1,2'b00,2'b10,0,0,2'b00,0);
                return mk(0,0,0,0,1,1,0,0,2'b00,2'b00,0,0,2'b00,0);
            end
            C_BRANCH: return mk(0,0,0,0,0,0,0,1,2'b00,2'b01,0,1,2'b01,0);
            C_JUMP:   return mk(0,0,0,0,0,0,0,0,2'b00,2'b00,1,0,2'b10,0);
            default:  return mk(0,0,0,0,0,0,0,0,2'b00,2'b00,0,0,2'b00,1);
        endcase
    endfunction

    function automatic int class_len(input int cls);
        case (cls)
            C_LOAD:                   return 5;
            C_STORE, C_RTYPE:         return 4;
            default:                  return 3;
        endcase
    endfunction

    function automatic string req_of(input int cls, input int k, input bit first);
        if (k == 1) return first ? "R1" : "R3";
        if (k == 2) return "R2";
        case (cls)
            C_LOAD:   return "R4";
            C_STORE:  return "R5";
            C_RTYPE:  return "R6";
            C_BRANCH: return "R7";
            C_JUMP:   return "R8";
            default:  return "R9";
        endcase
    endfunction

    function automatic logic [5:0] op_of(input int cls);
        case (cls)
            C_LOAD:   return 6'b100011;
            C_STORE:  return 6'b101011;
            C_RTYPE:  return 6'b000000;
            C_BRANCH: return 6'b000100;
            C_JUMP:   return 6'b000010;
            default: begin
                logic [5:0] v;
                v = 6'h3F;
                for (int t = 0; t < 32; t++) begin
                    v = 6'($urandom());
                    if (v != 6'b100011 && v != 6'b101011 && v != 6'b000000 &&
                        v != 6'b000100 && v != 6'b000010) break;
                    v = 6'h3F;
                end
                return v;
            end
        endcase
    endfunction

    function automatic logic [16:0] actual_word();
        return {mem_rd, mem_wr, addr_data, ir_wr, rf_wr, rf_dst_rd, rf_from_mem,
                alu_a_sel, alu_b_sel, alu_op, pc_wr, pc_wr_cond, pc_src, undef_op};
    endfunction

    bit prev_garbage = 1'b0;

    task automatic check_word(input logic [16:0] exp, input string req);
        logic [16:0] act;
        act = actual_word();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s%s: actual=%b expected=%b", req,
                     prev_garbage ? " R10" : "", act, exp);
        end
        checks++;
        if ((mem_rd && mem_wr) || $countones({mem_wr, rf_wr, pc_wr_cond, undef_op}) > 1) begin
            errors++;
            $display("FAIL R11: actual=%b expected=exclusive strobes", act);
        end
    endtask

    // Runs cycles 1..upto of one instruction; each call starts mid-fetch-cycle.
    task automatic run_cycles(input int cls, input logic [5:0] opv, input int upto,
                              input bit first);
        for (int k = 1; k <= upto; k++) begin
            bit use_op;
            check_word(expect_word(cls, k), req_of(cls, k, first && k == 1));
            use_op = (k == 2) || (k == 3 && (cls == C_LOAD || cls == C_STORE));
            opcode = use_op ? opv : 6'($urandom());
            prev_garbage = !use_op;
            @(negedge clk);
        end
    endtask

    task automatic run_instr(input int cls, input bit first);
        run_cycles(cls, op_of(cls), class_len(cls), first);
    endtask

    initial begin
        void'($urandom(32'h1234_5a5a));
        repeat (3) @(negedge clk);
        check_word(expect_word(0, 1), "R1");
        rst = 1'b0;
        run_instr(C_LOAD, 1'b1);
        run_instr(C_STORE, 1'b0);
        run_instr(C_RTYPE, 1'b0);
        run_instr(C_BRANCH, 1'b0);
        run_instr(C_JUMP, 1'b0);
        run_cycles(C_UNDEF, 6'h3F, 3, 1'b0);
        run_instr(C_UNDEF, 1'b0);
        run_instr(C_BRANCH, 1'b0);
        run_instr(C_BRANCH, 1'b0);
        // reset in the middle of a load (R1)
        run_cycles(C_LOAD, 6'b100011, 3, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        prev_garbage = 1'b0;
        check_word(expect_word(0, 1), "R1");
        rst = 1'b0;
        run_instr(C_STORE, 1'b1);
        for (int n = 0; n < 300; n++) begin
            run_instr(int'($urandom_range(0, 5)), 1'b0);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule